// File: doc/BRIEF.md
# Registered Bidirectional Bus Transceiver

This block links two parallel data buses, side A and side B. For each direction it can pass live data straight across, or replay a value held in a storage register. Every bit lane has two registers. The A-side register samples the value on the A pins and feeds traffic toward B. The B-side register samples the B pins and feeds traffic toward A. Each register has its own load strobe. A register loads on the first system clock edge at which its strobe is seen high after being low, whatever the selects and enables are doing.

Tri-state pins are not synthesizable, so each bus is split into three vectors: an external input vector, a driven output vector and an output-enable vector. A parameter chooses how the enables are produced. The dual style has one enable per direction, and both buses may drive at the same time. The single style has one group enable and a direction bit, so at most one bus drives. The value a register samples is the side's own driven value when that side's output is enabled, and the external input otherwise. This lets a single strobe edge copy live data into both registers.

Top module: `regbus_xcvr`

## Requirements
- R1: While `rst` is high at a rising `clk` edge, both storage registers of every lane clear to zero.
- R2: On the `clk` edge where `a_load` (or `b_load`) is first sampled high after being sampled low, the A-side (or B-side) register takes its side's pin value. Selects and enables do not affect this.
- R3: A load strobe that stays high, or stays low, across an edge leaves its register unchanged.
- R4: `b_out` equals `a_in` when `b_from_store`=0, and the A-side register when `b_from_store`=1. `a_out` equals `b_in` when `a_from_store`=0, and the B-side register when `a_from_store`=1. This holds whatever the enables are.
- R5: In the dual style (STYLE=CTL_DUAL), `b_oe` is all ones exactly when `ab_en`=1, and `a_oe` is all ones exactly when `ba_en_n`=0. Both may be set together. `grp_en_n` and `dir_to_b` have no effect.
- R6: In the single style (STYLE=CTL_SINGLE), `grp_en_n`=1 clears both enables. With `grp_en_n`=0, `dir_to_b`=1 sets only `b_oe`, and `dir_to_b`=0 sets only `a_oe`. Both are never set together, and `ab_en` and `ba_en_n` have no effect.
- R7: A register samples its side's driven output when that side's enable is set, and the side's external input otherwise. With B driving live A data, one edge of both strobes loads `a_in` into both registers.
- R8: If both strobes rise in the same cycle while B drives stored data, the B-side register receives the A-side register's previous contents, not the new A value.
- R9: When both buses drive with live selects, each live path takes the opposite side's external input, so the block has no combinational loop.
- R10: When the live and stored values of a direction are equal, toggling that direction's select leaves its output unchanged.

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| clk | input | 1 | System clock |
| rst | input | 1 | Synchronous active-high reset |
| a_in | input | WIDTH | External value on bus A |
| a_out | output | WIDTH | Value driven toward bus A |
| a_oe | output | WIDTH | Bus A output enable, per bit |
| b_in | input | WIDTH | External value on bus B |
| b_out | output | WIDTH | Value driven toward bus B |
| b_oe | output | WIDTH | Bus B output enable, per bit |
| ab_en | input | 1 | Dual style: enable B outputs, active high |
| ba_en_n | input | 1 | Dual style: enable A outputs, active low |
| grp_en_n | input | 1 | Single style: group output enable, active low |
| dir_to_b | input | 1 | Single style: 1 drives B, 0 drives A |
| b_from_store | input | 1 | Source for bus B: 0 live, 1 stored |
| a_from_store | input | 1 | Source for bus A: 0 live, 1 stored |
| a_load | input | 1 | Load strobe of the A-side register |
| b_load | input | 1 | Load strobe of the B-side register |

## Verification
The bench targets loads made while a side is driving. A design that sampled the external input instead of the pin would fail the store-in-both case, and one that read the new A value through the stored path would corrupt the simultaneous-strobe case. A strobe held high is checked, because a level-triggered register would keep reloading. Two instances, one per control style, share every stimulus. A mode that obeyed the wrong control pins, or enabled both buses in the single style, would show a wrong enable. Select toggles with equal live and stored data catch a mux that passes anything other than one of its two sources.

// File: rtl/xcvr_pkg.sv
package xcvr_pkg;
  typedef enum logic {
    CTL_DUAL   = 1'b0,
    CTL_SINGLE = 1'b1
  } ctl_style_e;
endpackage

// File: rtl/xcvr_rise.sv
// Turns a load strobe level into a one-cycle capture pulse on its rising edge.
module xcvr_rise (
  input  logic clk,
  input  logic rst,
  input  logic lvl,
  output logic rise
);
  logic prev_q;

  always_ff @(posedge clk) begin
    if (rst) prev_q <= 1'b0;
    else     prev_q <= lvl;
  end

  assign rise = lvl & ~prev_q;

  // R3: a capture pulse never lasts two cycles
  p_single_pulse_r3: assert property (@(posedge clk) disable iff (rst)
    rise |=> !rise);
endmodule

// File: rtl/xcvr_ctl.sv
// Output-enable decode; the parameter picks the control style.
module xcvr_ctl #(
  parameter xcvr_pkg::ctl_style_e STYLE = xcvr_pkg::CTL_DUAL
) (
  input  logic ab_en,
  input  logic ba_en_n,
  input  logic grp_en_n,
  input  logic dir_to_b,
  output logic drive_a,
  output logic drive_b
);
  generate
    if (STYLE == xcvr_pkg::CTL_DUAL) begin : g_dual
      logic unused_single;
      assign unused_single = grp_en_n ^ dir_to_b;
      assign drive_b = ab_en;
      assign drive_a = ~ba_en_n;
    end else begin : g_single
      logic unused_dual;
      assign unused_dual = ab_en ^ ba_en_n;
      assign drive_b = ~grp_en_n &  dir_to_b;
      assign drive_a = ~grp_en_n & ~dir_to_b;
      // R6: the single style never drives both buses
      always_comb begin
        p_never_both_r6: assert (!(drive_a && drive_b));
      end
    end
  endgenerate
endmodule

// File: rtl/xcvr_lane.sv
// One bit lane: two storage flops plus the per-direction source muxes.
module xcvr_lane (
  input  logic clk,
  input  logic rst,
  input  logic a_in,
  input  logic b_in,
  input  logic drive_a,
  input  logic drive_b,
  input  logic a_from_store,
  input  logic b_from_store,
  input  logic cap_a,
  input  logic cap_b,
  output logic a_out,
  output logic b_out,
  output logic a_q,
  output logic b_q
);
  logic a_pin, b_pin;

  // Live paths take the opposite external input, which keeps
  // the both-driving case free of a combinational loop.
  assign b_out = b_from_store ? a_q : a_in;
  assign a_out = a_from_store ? b_q : b_in;

  // What each register sees on its own pins.
  assign a_pin = drive_a ? a_out : a_in;
  assign b_pin = drive_b ? b_out : b_in;

  always_ff @(posedge clk) begin
    if (rst) begin
      a_q <= 1'b0;
      b_q <= 1'b0;
    end else begin
      if (cap_a) a_q <= a_pin;
      if (cap_b) b_q <= b_pin;
    end
  end

  // R2 / R7: a capture stores the pin value seen at that edge
  p_cap_a_r2: assert property (@(posedge clk) disable iff (rst)
    cap_a |=> a_q == $past(a_pin));
  p_cap_b_r7: assert property (@(posedge clk) disable iff (rst)
    cap_b |=> b_q == $past(b_pin));
  // R3: without a capture the register holds
  p_hold_a_r3: assert property (@(posedge clk) disable iff (rst)
    !cap_a |=> $stable(a_q));
endmodule

// File: rtl/regbus_xcvr.sv
module regbus_xcvr #(
  parameter int WIDTH = 8,
  parameter xcvr_pkg::ctl_style_e STYLE = xcvr_pkg::CTL_DUAL
) (
  input  logic             clk,
  input  logic             rst,
  input  logic [WIDTH-1:0] a_in,
  output logic [WIDTH-1:0] a_out,
  output logic [WIDTH-1:0] a_oe,
  input  logic [WIDTH-1:0] b_in,
  output logic [WIDTH-1:0] b_out,
  output logic [WIDTH-1:0] b_oe,
  input  logic             ab_en,
  input  logic             ba_en_n,
  input  logic             grp_en_n,
  input  logic             dir_to_b,
  input  logic             b_from_store,
  input  logic             a_from_store,
  input  logic             a_load,
  input  logic             b_load
);
  logic drive_a, drive_b;
  logic cap_a, cap_b;
  logic [WIDTH-1:0] a_store, b_store;

  xcvr_ctl #(.STYLE(STYLE)) u_ctl (
    .ab_en(ab_en), .ba_en_n(ba_en_n), .grp_en_n(grp_en_n),
    .dir_to_b(dir_to_b), .drive_a(drive_a), .drive_b(drive_b)
  );

  xcvr_rise u_rise_a (.clk(clk), .rst(rst), .lvl(a_load), .rise(cap_a));
  xcvr_rise u_rise_b (.clk(clk), .rst(rst), .lvl(b_load), .rise(cap_b));

  assign a_oe = {WIDTH{drive_a}};
  assign b_oe = {WIDTH{drive_b}};

  for (genvar i = 0; i < WIDTH; i++) begin : g_lane
    xcvr_lane u_lane (
      .clk(clk), .rst(rst),
      .a_in(a_in[i]), .b_in(b_in[i]),
      .drive_a(drive_a), .drive_b(drive_b),
      .a_from_store(a_from_store), .b_from_store(b_from_store),
      .cap_a(cap_a), .cap_b(cap_b),
      .a_out(a_out[i]), .b_out(b_out[i]),
      .a_q(a_store[i]), .b_q(b_store[i])
    );
  end

  // R1: reset clears both register banks
  p_clear_r1: assert property (@(posedge clk)
    rst |=> (a_store == '0 && b_store == '0));
  // R10: equal live and stored data leave the A output unaffected by its select
  p_no_glitch_r10: assert property (@(posedge clk) disable iff (rst)
    (b_in == b_store) |-> (a_out == b_in));
  // R8: same-cycle stored transfer hands B the old A contents
  p_stagger_r8: assert property (@(posedge clk) disable iff (rst)
    (cap_a && cap_b && drive_b && b_from_store) |=> b_store == $past(a_store));
  // R9: both driving with live selects takes external inputs
  p_live_both_r9: assert property (@(posedge clk) disable iff (rst)
    (drive_a && drive_b && !a_from_store && !b_from_store)
      |-> (a_out == b_in && b_out == a_in));
endmodule

// File: tb/regbus_xcvr_tb.sv
module regbus_xcvr_tb;
  localparam int CLK_PERIOD = 10;
  localparam int W = 8;

  logic clk = 1'b0;
  logic rst = 1'b1;
  logic [W-1:0] a_in = '0, b_in = '0;
  logic ab_en = 1'b0, ba_en_n = 1'b1, grp_en_n = 1'b1, dir_to_b = 1'b0;
  logic b_from_store = 1'b0, a_from_store = 1'b0;
  logic a_load = 1'b0, b_load = 1'b0;
  logic [W-1:0] da_out, da_oe, db_out, db_oe;
  logic [W-1:0] sa_out, sa_oe, sb_out, sb_oe;

  int checks = 0;
  int errors = 0;
  bit done = 1'b0;

  always #(CLK_PERIOD/2) clk = ~clk;

  regbus_xcvr #(.WIDTH(W), .STYLE(xcvr_pkg::CTL_DUAL)) u_dut (
    .clk(clk), .rst(rst), .a_in(a_in), .a_out(da_out), .a_oe(da_oe),
    .b_in(b_in), .b_out(db_out), .b_oe(db_oe), .ab_en(ab_en),
    .ba_en_n(ba_en_n), .grp_en_n(grp_en_n), .dir_to_b(dir_to_b),
    .b_from_store(b_from_store), .a_from_store(a_from_store),
    .a_load(a_load), .b_load(b_load)
  );

  regbus_xcvr #(.WIDTH(W), .STYLE(xcvr_pkg::CTL_SINGLE)) u_dut_single (
    .clk(clk), .rst(rst), .a_in(a_in), .a_out(sa_out), .a_oe(sa_oe),
    .b_in(b_in), .b_out(sb_out), .b_oe(sb_oe), .ab_en(ab_en),
    .ba_en_n(ba_en_n), .grp_en_n(grp_en_n), .dir_to_b(dir_to_b),
    .b_from_store(b_from_store), .a_from_store(a_from_store),
    .a_load(a_load), .b_load(b_load)
  );

  typedef struct packed {
    logic ab_en, ba_en_n, grp_en_n, dir_to_b;
    logic sab, sba;
    logic [7:0] ai, bi;
    logic d_aoe, d_boe, s_aoe, s_boe;
    logic [7:0] aout, bout;
  } row_t;

  // Stored contents during the table: A-side 3C, B-side A5 in both instances.
  localparam row_t TBL [8] = '{
    '{1'b0,1'b1,1'b1,1'b0, 1'b0,1'b0, 8'h11,8'h22, 1'b0,1'b0,1'b0,1'b0, 8'h22,8'h11},
    '{1'b1,1'b1,1'b0,1'b1, 1'b0,1'b0, 8'h5A,8'h22, 1'b0,1'b1,1'b0,1'b1, 8'h22,8'h5A},
    '{1'b1,1'b1,1'b0,1'b0, 1'b1,1'b0, 8'h5A,8'h22, 1'b0,1'b1,1'b1,1'b0, 8'h22,8'h3C},
    '{1'b0,1'b0,1'b1,1'b1, 1'b0,1'b0, 8'h11,8'hC3, 1'b1,1'b0,1'b0,1'b0, 8'hC3,8'h11},
    '{1'b0,1'b0,1'b0,1'b1, 1'b0,1'b1, 8'h11,8'hC3, 1'b1,1'b0,1'b0,1'b1, 8'hA5,8'h11},
    '{1'b1,1'b0,1'b0,1'b0, 1'b1,1'b1, 8'h77,8'h88, 1'b1,1'b1,1'b1,1'b0, 8'hA5,8'h3C},
    '{1'b1,1'b0,1'b1,1'b0, 1'b0,1'b0, 8'h77,8'h88, 1'b1,1'b1,1'b0,1'b0, 8'h88,8'h77},
    '{1'b0,1'b1,1'b0,1'b1, 1'b1,1'b1, 8'hF0,8'h0F, 1'b0,1'b0,1'b0,1'b1, 8'hA5,8'h3C}
  };

  task automatic chk(input string req, input logic [W-1:0] act, input logic [W-1:0] exp);
    checks++;
    if (act !== exp) begin
      errors++;
      $display("FAIL %s actual=%h expected=%h", req, act, exp);
    end
  endtask

  task automatic isolate();
    ab_en = 1'b0; ba_en_n = 1'b1; grp_en_n = 1'b1;
  endtask

  // Raise the chosen strobes for exactly one sampled edge.
  task automatic pulse(input logic la, input logic lb);
    @(negedge clk); a_load = la; b_load = lb;
    @(negedge clk); a_load = 1'b0; b_load = 1'b0;
    #1;
  endtask

  task automatic view_stored();
    @(negedge clk); isolate(); b_from_store = 1'b1; a_from_store = 1'b1; #1;
  endtask

  initial begin
    #(CLK_PERIOD * 20000);
    if (!done) begin
      errors++;
      $display("FAIL watchdog actual=running expected=finished");
      $display("CHECKS %0d ERRORS %0d", checks, errors);
      $finish;
    end
  end

  initial begin
    repeat (3) @(negedge clk);
    rst = 1'b0;
    // R1: registers cleared, seen through the stored paths
    view_stored();
    chk("R1 dual b_out", db_out, 8'h00);
    chk("R1 dual a_out", da_out, 8'h00);
    chk("R1 single a_out", sa_out, 8'h00);

    // R2: load A=3C, B=A5 while isolated; R3: strobes held high, inputs change
    @(negedge clk); a_in = 8'h3C; b_in = 8'hA5; b_from_store = 1'b0; a_from_store = 1'b0;
    a_load = 1'b1; b_load = 1'b1;
    @(negedge clk); a_in = 8'hFF; b_in = 8'hFF;
    @(negedge clk); a_load = 1'b0; b_load = 1'b0;
    view_stored();
    chk("R2/R3 A-side reg", db_out, 8'h3C);
    chk("R2/R3 B-side reg", da_out, 8'hA5);
    chk("R3 single B-side reg", sa_out, 8'hA5);

    // R4 R5 R6 R9: table walk
    foreach (TBL[i]) begin
      @(negedge clk);
      ab_en = TBL[i].ab_en; ba_en_n = TBL[i].ba_en_n;
      grp_en_n = TBL[i].grp_en_n; dir_to_b = TBL[i].dir_to_b;
      b_from_store = TBL[i].sab; a_from_store = TBL[i].sba;
      a_in = TBL[i].ai; b_in = TBL[i].bi;
      #1;
      chk($sformatf("R5 row%0d dual a_oe", i), da_oe, {W{TBL[i].d_aoe}});
      chk($sformatf("R5 row%0d dual b_oe", i), db_oe, {W{TBL[i].d_boe}});
      chk($sformatf("R6 row%0d single a_oe", i), sa_oe, {W{TBL[i].s_aoe}});
      chk($sformatf("R6 row%0d single b_oe", i), sb_oe, {W{TBL[i].s_boe}});
      chk($sformatf("R4/R9 row%0d a_out", i), da_out, TBL[i].aout);
      chk($sformatf("R4/R9 row%0d b_out", i), db_out, TBL[i].bout);
      chk($sformatf("R4 row%0d single b_out", i), sb_out, TBL[i].bout);
    end

    // R7: B driving live A data, one edge stores a_in into both (dual)
    @(negedge clk); isolate(); ab_en = 1'b1; b_from_store = 1'b0; a_from_store = 1'b0;
    a_in = 8'h66; b_in = 8'h99;
    pulse(1'b1, 1'b1);
    view_stored();
    chk("R7 dual A-side reg", db_out, 8'h66);
    chk("R7 dual B-side reg", da_out, 8'h66);
    chk("R7 single B-side from external", sa_out, 8'h99);

    // R2: isolated B load of 44 into both instances
    @(negedge clk); b_from_store = 1'b0; a_from_store = 1'b0; b_in = 8'h44;
    pulse(1'b0, 1'b1);
    view_stored();
    chk("R2 B-side reg", da_out, 8'h44);

    // R8: both strobes together with stored A driving B
    @(negedge clk); ab_en = 1'b1; b_from_store = 1'b1; a_from_store = 1'b0;
    a_in = 8'h12; b_in = 8'h99;
    pulse(1'b1, 1'b1);
    view_stored();
    chk("R8 dual A-side reg", db_out, 8'h12);
    chk("R8 dual B-side gets old A", da_out, 8'h66);
    chk("R8 single B-side from external", sa_out, 8'h99);

    // R10: live equals stored (66), select toggles
    @(negedge clk); a_from_store = 1'b0; b_in = 8'h66; #1;
    chk("R10 live", da_out, 8'h66);
    a_from_store = 1'b1; #1;
    chk("R10 stored", da_out, 8'h66);

    // R1: reset in mid run
    @(negedge clk); rst = 1'b1;
    @(negedge clk); rst = 1'b0;
    view_stored();
    chk("R1 mid-run dual A-side", db_out, 8'h00);
    chk("R1 mid-run single B-side", sa_out, 8'h00);

    done = 1'b1;
    $display("CHECKS %0d ERRORS %0d", checks, errors);
    $finish;
  end
endmodule